// File: doc/BRIEF.md
# Write-Back Write-Allocate Cache Controller

This block is a set-associative cache controller that can be placed at any level of a memory hierarchy. Requests come in from above (a processor or a higher cache) one at a time over a valid/ready port, and each request is answered with a single-cycle response pulse. Hits are served locally. Writes change only the local copy and mark the line dirty.

A miss starts an allocation in two strict steps. The first step picks a way in the indexed set. The lowest-numbered invalid way is used if one exists. Otherwise a replacement unit names a victim, and if that victim is dirty the whole block is written to the next level and must complete there. The second step reads the requested block from the next level, installs it, and replays the request as a hit. The replacement unit is chosen by parameter: exact least-recently-used ordering, or a binary pseudo-LRU tree with one bit per internal node.

Capacity, associativity and block size are parameters. The number of sets is capacity / (associativity × block size). Both the set count and the block size must be powers of two. The tree option also needs a power-of-two associativity, and an illegal configuration stops elaboration.

Top module: `cache_wbwa`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `dn_valid` and `rsp_valid` are 0.
- R2: A read hit returns the addressed 32-bit word (word select = address bits [3:2] with default parameters) in `rsp_rdata` and causes no downstream request.
- R3: A miss in a set that has an invalid way fills the lowest-numbered invalid way with exactly one downstream block read (`dn_write`=0) at the block-aligned address, and writes nothing back.
- R4: A write hit updates only the local word, sets the line's dirty bit and causes no downstream request; a later read of that word returns the written value.
- R5: A write miss allocates the block like a read miss. The written word is then merged into the block and the line is dirty.
- R6: Evicting a clean victim produces no writeback; only the read of the new block is issued.
- R7: Evicting a dirty victim first issues a full-block write (`dn_write`=1) of the victim's current contents at the victim's address. That write completes before the block read is issued. Every downstream request holds its address and direction until `dn_ready`.
- R8: With the exact-LRU policy (`POLICY`=0), the victim is the way touched least recently, and hits as well as fills count as touches.
- R9: With the tree policy (`POLICY`=1), each touch points the tree bits on its path away from the touched way, and the victim is found by following those bits from the root (bit 1 = right half).
- R10: Only one request is in flight: `req_ready` falls in the cycle after a request is accepted, and `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address (word aligned) |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Read word (the written word for writes) |
| dn_valid | output | 1 | Downstream request active |
| dn_write | output | 1 | 1 = block writeback, 0 = block read |
| dn_addr | output | ADDR_W | Block-aligned downstream address |
| dn_wdata | output | BLOCK_BYTES*8 | Writeback block |
| dn_ready | input | 1 | Next level completes the request this cycle |
| dn_rdata | input | BLOCK_BYTES*8 | Read block, valid with `dn_ready` |

## Verification
A damaged dirty bit or tag never shows up at the moment it is corrupted. It appears later, when its set is next evicted: a writeback goes missing, an extra one is sent, or one carries the wrong address or data. The tests therefore drive each set until it is full and then force evictions. A wrong recency state is visible only through the victim it selects, so the eviction tests follow each one with a hit/miss probe of the surviving and the evicted block. Both probes show at the downstream port within a few cycles.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic {
        REPL_LRU  = 1'b0,
        REPL_PLRU = 1'b1
    } repl_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FETCH
    } ctl_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_flags_t;

    function automatic int unsigned sel_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic bit is_pow2(input int unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/cache_lookup.sv
module cache_lookup #(
    parameter int unsigned ASSOC = 4,
    parameter int unsigned TAG_W = 10,
    localparam int unsigned WAY_W = cache_pkg::sel_width(ASSOC)
) (
    input  logic [ASSOC-1:0]            way_valid,
    input  logic [ASSOC-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        any_free,
    output logic [WAY_W-1:0]            free_way
);
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        any_free = 1'b0;
        free_way = '0;
        for (int w = 0; w < int'(ASSOC); w++) begin
            if (way_valid[w] && (way_tag[w] == probe_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        for (int w = int'(ASSOC) - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cache_repl.sv
module cache_repl #(
    parameter int unsigned          SETS   = 4,
    parameter int unsigned          ASSOC  = 4,
    parameter cache_pkg::repl_kind_e POLICY = cache_pkg::REPL_LRU,
    localparam int unsigned WAY_W = cache_pkg::sel_width(ASSOC),
    localparam int unsigned SET_W = cache_pkg::sel_width(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);
    if (ASSOC == 1) begin : g_direct
        logic unused_in;
        assign unused_in  = ^{clk, rst, touch_en, touch_set, touch_way, query_set};
        assign victim_way = '0;
    end else if (POLICY == cache_pkg::REPL_LRU) begin : g_lru
        // age 0 = most recent, ASSOC-1 = least recent; ages stay a permutation
        logic [WAY_W-1:0] age_q [SETS][ASSOC];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < int'(SETS); s++)
                    for (int w = 0; w < int'(ASSOC); w++)
                        age_q[s][w] <= WAY_W'(w);
            end else if (touch_en) begin
                for (int w = 0; w < int'(ASSOC); w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[touch_set][w] <= '0;
                    else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                        age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
                end
            end
        end

        always_comb begin
            victim_way = '0;
            for (int w = 0; w < int'(ASSOC); w++)
                if (age_q[query_set][w] == WAY_W'(ASSOC - 1))
                    victim_way = WAY_W'(w);
        end
    end else begin : g_plru
        localparam int unsigned NODES  = ASSOC - 1;
        localparam int unsigned LEVELS = $clog2(ASSOC);

        logic [NODES-1:0] tree_q [SETS];
        logic [NODES-1:0] tree_next;

        // node n has children 2n+1 (left) and 2n+2 (right); 1 = victim on right
        always_comb begin
            int node;
            tree_next = tree_q[touch_set];
            node = 0;
            for (int lvl = 0; lvl < int'(LEVELS); lvl++) begin
                tree_next[node] = ~touch_way[LEVELS-1-lvl];
                node = 2 * node + 1 + int'(touch_way[LEVELS-1-lvl]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < int'(SETS); s++)
                    tree_q[s] <= '0;
            end else if (touch_en) begin
                tree_q[touch_set] <= tree_next;
            end
        end

        always_comb begin
            int node;
            victim_way = '0;
            node = 0;
            for (int lvl = 0; lvl < int'(LEVELS); lvl++) begin
                victim_way[LEVELS-1-lvl] = tree_q[query_set][node];
                node = 2 * node + 1 + int'(tree_q[query_set][node]);
            end
        end
    end
endmodule

// File: rtl/cache_wbwa.sv
module cache_wbwa #(
    parameter int unsigned           ADDR_W      = 16,
    parameter int unsigned           WORD_W      = 32,
    parameter int unsigned           SIZE_BYTES  = 256,
    parameter int unsigned           ASSOC       = 4,
    parameter int unsigned           BLOCK_BYTES = 16,
    parameter cache_pkg::repl_kind_e POLICY      = cache_pkg::REPL_LRU,
    localparam int unsigned LINE_W = BLOCK_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [LINE_W-1:0] dn_wdata,
    input  logic              dn_ready,
    input  logic [LINE_W-1:0] dn_rdata
);
    import cache_pkg::*;

    localparam int unsigned SETS   = SIZE_BYTES / (ASSOC * BLOCK_BYTES);
    localparam int unsigned OFF_W  = $clog2(BLOCK_BYTES);
    localparam int unsigned IDX_W  = sel_width(SETS);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned WAY_W  = sel_width(ASSOC);
    localparam int unsigned WORDS  = LINE_W / WORD_W;
    localparam int unsigned WSEL_W = sel_width(WORDS);
    localparam int unsigned BOFF_W = $clog2(WORD_W / 8);

    if (!is_pow2(BLOCK_BYTES) || !is_pow2(SETS) || SETS < 2 || WORDS < 2 ||
        SETS * ASSOC * BLOCK_BYTES != SIZE_BYTES ||
        (POLICY == REPL_PLRU && !is_pow2(ASSOC))) begin : g_bad_cfg
        $error("cache_wbwa: illegal geometry or policy combination");
    end

    // ---------------- storage ----------------
    line_flags_t       flags_q [SETS][ASSOC];
    logic [TAG_W-1:0]  tag_q   [SETS][ASSOC];
    logic [LINE_W-1:0] data_q  [SETS][ASSOC];

    // ---------------- request registers ----------------
    ctl_state_e        state_q;
    logic [TAG_W-1:0]  rq_tag;
    logic [IDX_W-1:0]  rq_idx;
    logic [WSEL_W-1:0] rq_wsel;
    logic              rq_write;
    logic [WORD_W-1:0] rq_wdata;
    logic [WAY_W-1:0]  alloc_way_q;
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_rdata_q;

    logic unused_addr_bits;
    assign unused_addr_bits = ^req_addr[BOFF_W-1:0];

    // ---------------- lookup ----------------
    logic [ASSOC-1:0]            set_vld;
    logic [ASSOC-1:0][TAG_W-1:0] set_tags;
    logic                        lk_hit;
    logic [WAY_W-1:0]            lk_way;
    logic                        lk_free;
    logic [WAY_W-1:0]            lk_free_way;
    logic [WAY_W-1:0]            victim_way;
    logic [WAY_W-1:0]            pick_way;
    logic                        lk_fire;
    logic [WORD_W-1:0]           hit_word;

    always_comb begin
        for (int w = 0; w < int'(ASSOC); w++) begin
            set_vld[w]  = flags_q[rq_idx][w].valid;
            set_tags[w] = tag_q[rq_idx][w];
        end
    end

    cache_lookup #(.ASSOC(ASSOC), .TAG_W(TAG_W)) u_lookup (
        .way_valid (set_vld),
        .way_tag   (set_tags),
        .probe_tag (rq_tag),
        .hit       (lk_hit),
        .hit_way   (lk_way),
        .any_free  (lk_free),
        .free_way  (lk_free_way)
    );

    assign lk_fire  = (state_q == ST_LOOKUP);
    assign pick_way = lk_free ? lk_free_way : victim_way;
    assign hit_word = data_q[rq_idx][lk_way][int'(rq_wsel)*WORD_W +: WORD_W];

    cache_repl #(.SETS(SETS), .ASSOC(ASSOC), .POLICY(POLICY)) u_repl (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (lk_fire && lk_hit),
        .touch_set  (rq_idx),
        .touch_way  (lk_way),
        .query_set  (rq_idx),
        .victim_way (victim_way)
    );

    // ---------------- control and flags ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            rq_tag      <= '0;
            rq_idx      <= '0;
            rq_wsel     <= '0;
            rq_write    <= 1'b0;
            rq_wdata    <= '0;
            alloc_way_q <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            for (int s = 0; s < int'(SETS); s++)
                for (int w = 0; w < int'(ASSOC); w++)
                    flags_q[s][w] <= '{valid: 1'b0, dirty: 1'b0};
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq_tag   <= req_addr[ADDR_W-1 -: TAG_W];
                        rq_idx   <= req_addr[OFF_W +: IDX_W];
                        rq_wsel  <= req_addr[BOFF_W +: WSEL_W];
                        rq_write <= req_write;
                        rq_wdata <= req_wdata;
                        state_q  <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (lk_hit) begin
                        if (rq_write)
                            flags_q[rq_idx][lk_way].dirty <= 1'b1;
                        rsp_valid_q <= 1'b1;
                        rsp_rdata_q <= rq_write ? rq_wdata : hit_word;
                        state_q     <= ST_IDLE;
                    end else begin
                        alloc_way_q <= pick_way;
                        state_q <= (!lk_free && flags_q[rq_idx][victim_way].dirty)
                                   ? ST_EVICT : ST_FETCH;
                    end
                end
                ST_EVICT: begin
                    if (dn_ready)
                        state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (dn_ready) begin
                        flags_q[rq_idx][alloc_way_q] <= '{valid: 1'b1, dirty: 1'b0};
                        state_q <= ST_LOOKUP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- tag and data arrays ----------------
    always_ff @(posedge clk) begin
        if (lk_fire && lk_hit && rq_write)
            data_q[rq_idx][lk_way][int'(rq_wsel)*WORD_W +: WORD_W] <= rq_wdata;
        if (state_q == ST_FETCH && dn_ready) begin
            data_q[rq_idx][alloc_way_q] <= dn_rdata;
            tag_q[rq_idx][alloc_way_q]  <= rq_tag;
        end
    end

    // ---------------- ports ----------------
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
    assign dn_valid  = (state_q == ST_EVICT) || (state_q == ST_FETCH);
    assign dn_write  = (state_q == ST_EVICT);
    assign dn_addr   = (state_q == ST_EVICT)
                     ? {tag_q[rq_idx][alloc_way_q], rq_idx, {OFF_W{1'b0}}}
                     : {rq_tag, rq_idx, {OFF_W{1'b0}}};
    assign dn_wdata  = data_q[rq_idx][alloc_way_q];

endmodule

// File: rtl/cache_wbwa_sva.sv
module cache_wbwa_sva #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              dn_valid,
    input logic              dn_write,
    input logic              dn_ready,
    input logic [ADDR_W-1:0] dn_addr,
    input logic              lk_fire,
    input logic              lk_hit
);
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R10

    AST_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (lk_fire && lk_hit) |=> !dn_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !dn_valid); // R3

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write))); // R7

    AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_write && dn_ready) |=> (dn_valid && !dn_write)); // R7

    AST_FILL_REPLAYS_HIT: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_write && dn_ready) |=> (lk_fire && lk_hit)); // R5
endmodule

bind cache_wbwa cache_wbwa_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .dn_valid  (dn_valid),
    .dn_write  (dn_write),
    .dn_ready  (dn_ready),
    .dn_addr   (dn_addr),
    .lk_fire   (lk_fire),
    .lk_hit    (lk_hit)
);

// File: tb/cache_wbwa_bench.sv
`timescale 1ns/1ps
module cache_wbwa_bench;
    localparam int LW = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          req_valid [2];
    logic          req_ready [2];
    logic          req_write [2];
    logic [15:0]   req_addr  [2];
    logic [31:0]   req_wdata [2];
    logic          rsp_valid [2];
    logic [31:0]   rsp_rdata [2];
    logic          dn_valid  [2];
    logic          dn_write  [2];
    logic [15:0]   dn_addr   [2];
    logic [LW-1:0] dn_wdata  [2];
    logic          dn_ready  [2];
    logic [LW-1:0] dn_rdata  [2];

    int n_chk = 0;
    int n_bad = 0;

    cache_wbwa #(.POLICY(cache_pkg::REPL_LRU)) u_cache_wbwa (
        .clk(clk), .rst(rst),
        .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write[0]),
        .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
        .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]),
        .dn_valid(dn_valid[0]), .dn_write(dn_write[0]), .dn_addr(dn_addr[0]),
        .dn_wdata(dn_wdata[0]), .dn_ready(dn_ready[0]), .dn_rdata(dn_rdata[0]));

    cache_wbwa #(.POLICY(cache_pkg::REPL_PLRU)) u_cache_wbwa_plru (
        .clk(clk), .rst(rst),
        .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write[1]),
        .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
        .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]),
        .dn_valid(dn_valid[1]), .dn_write(dn_write[1]), .dn_addr(dn_addr[1]),
        .dn_wdata(dn_wdata[1]), .dn_ready(dn_ready[1]), .dn_rdata(dn_rdata[1]));

    function automatic logic [LW-1:0] line_pat(input logic [15:0] a);
        logic [LW-1:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = {a, 8'hC3, 8'(i)};
        return v;
    endfunction

    // next-level model: completes each request after three cycles, logs it
    int            lat   [2];
    int            lg_n  [2];
    logic          lg_wr   [2][32];
    logic [15:0]   lg_addr [2][32];
    logic [LW-1:0] lg_data [2][32];

    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                dn_ready[d] <= 1'b0;
                dn_rdata[d] <= '0;
                lat[d]      <= 0;
                lg_n[d]     <= 0;
            end else if (dn_ready[d]) begin
                dn_ready[d] <= 1'b0;
            end else if (dn_valid[d]) begin
                if (lat[d] == 2) begin
                    lat[d]      <= 0;
                    dn_ready[d] <= 1'b1;
                    dn_rdata[d] <= line_pat(dn_addr[d]);
                    if (lg_n[d] < 32) begin
                        lg_wr[d][lg_n[d]]   <= dn_write[d];
                        lg_addr[d][lg_n[d]] <= dn_addr[d];
                        lg_data[d][lg_n[d]] <= dn_wdata[d];
                        lg_n[d]             <= lg_n[d] + 1;
                    end
                end else begin
                    lat[d] <= lat[d] + 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input int d, input bit wr, input logic [15:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        int t;
        @(negedge clk);
        req_valid[d] = 1'b1; req_write[d] = wr; req_addr[d] = a; req_wdata[d] = wd;
        t = 0;
        while (!req_ready[d] && t < 200) begin @(negedge clk); t++; end
        @(negedge clk);
        req_valid[d] = 1'b0;
        check("R10 busy after accept", LW'(req_ready[d]), LW'(0));
        t = 0;
        while (!rsp_valid[d] && t < 200) begin @(negedge clk); t++; end
        check("R10 response arrived", LW'(rsp_valid[d]), LW'(1));
        rd = rsp_rdata[d];
        @(negedge clk);
        check("R10 response single cycle", LW'(rsp_valid[d]), LW'(0));
    endtask

    task automatic check_log(input string req, input int d, input int k,
                             input bit wr, input logic [15:0] a);
        check({req, " downstream direction"}, LW'(lg_wr[d][k]), LW'(wr));
        check({req, " downstream address"}, LW'(lg_addr[d][k]), LW'(a));
    endtask

    task automatic t_reset();
        for (int d = 0; d < 2; d++) begin
            check("R1 req_ready", LW'(req_ready[d]), LW'(1));
            check("R1 dn_valid", LW'(dn_valid[d]), LW'(0));
            check("R1 rsp_valid", LW'(rsp_valid[d]), LW'(0));
        end
    endtask

    task automatic t_read_miss_hit();
        logic [31:0] rd; int b;
        b = lg_n[0];
        access(0, 0, 16'h0040, 0, rd);
        check("R3 miss data", LW'(rd), LW'(line_pat(16'h0040)[31:0]));
        check("R3 one read only", LW'(lg_n[0] - b), LW'(1));
        check_log("R3", 0, b, 1'b0, 16'h0040);
        access(0, 0, 16'h0044, 0, rd);
        check("R2 hit word1", LW'(rd), LW'(line_pat(16'h0040)[63:32]));
        check("R2 hit no downstream", LW'(lg_n[0] - b), LW'(1));
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; int b;
        b = lg_n[0];
        access(0, 1, 16'h0048, 32'hDEADBEEF, rd);
        check("R4 write hit no downstream", LW'(lg_n[0] - b), LW'(0));
        access(0, 0, 16'h0048, 0, rd);
        check("R4 readback", LW'(rd), LW'(32'hDEADBEEF));
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; int b;
        b = lg_n[0];
        access(0, 1, 16'h0084, 32'h11112222, rd);
        check("R5 single fill", LW'(lg_n[0] - b), LW'(1));
        check_log("R5", 0, b, 1'b0, 16'h0080);
        access(0, 0, 16'h0084, 0, rd);
        check("R5 merged word", LW'(rd), LW'(32'h11112222));
    endtask

    task automatic t_evictions();
        logic [31:0] rd; int b; logic [LW-1:0] exp_line;
        access(0, 0, 16'h00C0, 0, rd);
        access(0, 0, 16'h0100, 0, rd);
        b = lg_n[0];
        // set 0 full, 0x0040 least recent and dirty
        access(0, 0, 16'h0140, 0, rd);
        exp_line = line_pat(16'h0040);
        exp_line[95:64] = 32'hDEADBEEF;
        check("R7 two transfers", LW'(lg_n[0] - b), LW'(2));
        check_log("R7 writeback first", 0, b, 1'b1, 16'h0040);
        check("R7 writeback data R4", lg_data[0][b], exp_line);
        check_log("R7 fill second", 0, b + 1, 1'b0, 16'h0140);
        check("R7 new data", LW'(rd), LW'(line_pat(16'h0140)[31:0]));
        // touch 0x0080 so the clean 0x00C0 becomes least recent
        access(0, 0, 16'h0080, 0, rd);
        b = lg_n[0];
        access(0, 0, 16'h0180, 0, rd);
        check("R6 clean victim one read", LW'(lg_n[0] - b), LW'(1));
        check_log("R6", 0, b, 1'b0, 16'h0180);
        access(0, 0, 16'h0088, 0, rd);
        check("R8 hit-touched block kept", LW'(lg_n[0] - b), LW'(1));
        check("R8 kept data", LW'(rd), LW'(line_pat(16'h0080)[95:64]));
    endtask

    task automatic fill_set1(input int d);
        logic [31:0] rd;
        access(d, 0, 16'h0050, 0, rd);
        access(d, 0, 16'h0090, 0, rd);
        access(d, 0, 16'h00D0, 0, rd);
        access(d, 0, 16'h0110, 0, rd);
        access(d, 0, 16'h0050, 0, rd);
        access(d, 0, 16'h0150, 0, rd);
    endtask

    task automatic t_policies();
        logic [31:0] rd; int b;
        fill_set1(0);
        b = lg_n[0];
        access(0, 0, 16'h00D0, 0, rd);
        check("R8 LRU keeps 0x00D0", LW'(lg_n[0] - b), LW'(0));
        access(0, 0, 16'h0090, 0, rd);
        check("R8 LRU evicted 0x0090", LW'(lg_n[0] - b), LW'(1));
        check_log("R8", 0, b, 1'b0, 16'h0090);

        b = lg_n[1];
        fill_set1(1);
        check("R3 tree cache reads only", LW'(lg_n[1] - b), LW'(5));
        for (int k = 0; k < 5; k++)
            check("R3 no writeback of clean lines", LW'(lg_wr[1][b + k]), LW'(0));
        b = lg_n[1];
        access(1, 0, 16'h0090, 0, rd);
        check("R9 tree keeps 0x0090", LW'(lg_n[1] - b), LW'(0));
        access(1, 0, 16'h00D0, 0, rd);
        check("R9 tree evicted 0x00D0", LW'(lg_n[1] - b), LW'(1));
        check_log("R9", 1, b, 1'b0, 16'h00D0);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            req_valid[d] = 1'b0; req_write[d] = 1'b0;
            req_addr[d] = '0; req_wdata[d] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_write_hit();
        t_write_miss();
        t_evictions();
        t_policies();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule